// File: doc/BRIEF.md
# Television Sync Timing Generator

This block produces the horizontal and vertical sync pulses for 525-line and 625-line television rasters. Both pulses are active low. One set of pixel and line counters covers three standards: NTSC and PAL60 on the 525-line raster, and PAL on the 625-line raster. Each standard can run interlaced, where a frame holds two fields offset by half a line. It can also run progressive, where every field repeats the odd-field timing. A downstream video path uses it as its timing master. That path takes the exported line number and field flag to blank pixel data.

A role input picks master or slave. In master mode the output enable is driven high so the sync pins carry this block's pulses. In slave mode the enable is low so an external source can own the lines. A clock-mode input picks how the counters advance. They either step on every clock, or on every second clock when a double-rate clock is supplied. The raster origin is fixed by the active-low reset. The first clock edge after reset is released places the counters at pixel 0 of line 0, which is the start of the odd field.

Top module: `syncTimingGen`

## Requirements
- R1: `syncOe` is 1 whenever `masterSel` is 1 and 0 whenever it is 0, at all times.
- R2: While `rstN` is low, `hsyncO` and `vsyncO` are 1, `lineCount` is 0 and `oddField` is 1. From the first clock edge after release, the block shows pixel 0 of line 0, with both syncs low.
- R3: `stdSel` coding is 0 NTSC, 1 PAL, 2 PAL60, and 3 treated as NTSC. A line lasts LINE_625 pixel steps for PAL and LINE_525 for the others. `hsyncO` is low for the first HSYNC_W pixel steps of every line.
- R4: `lineCount` counts lines from 0 and steps by one at each line end. When `interlace`=1 it wraps after LINES_525 lines (NTSC, PAL60) or LINES_625 lines (PAL). When `interlace`=0 it wraps after (lines+1)/2 lines.
- R5: In the odd field, and in every progressive field, `vsyncO` falls together with `hsyncO` at pixel 0 of line 0. It stays low for VSYNC_LINES whole lines.
- R6: In interlaced mode the even-field `vsyncO` falls at pixel lineLength/2 of line (lines-1)/2, while `hsyncO` is high. It rises at the same pixel VSYNC_LINES lines later.
- R7: `oddField` is 1 from line 0 pixel 0 until the even-field start point of R6, and 0 after it. In progressive mode it is always 1.
- R8: With `clkDirect`=0 every pixel step lasts two clocks, so each HSYNC pulse is 2*HSYNC_W clocks long. With `clkDirect`=1 it lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (single or double rate) |
| rstN | input | 1 | Active-low asynchronous reset; release sets the raster origin |
| masterSel | input | 1 | 1 = master (drive sync lines), 0 = slave |
| clkDirect | input | 1 | 1 = step every clock, 0 = step every second clock |
| stdSel | input | 2 | 0 NTSC, 1 PAL, 2 PAL60, 3 as NTSC |
| interlace | input | 1 | 1 = interlaced, 0 = progressive |
| hsyncO | output | 1 | Horizontal sync, active low |
| vsyncO | output | 1 | Vertical sync, active low |
| syncOe | output | 1 | Output enable for the sync pads |
| lineCount | output | LW | Current line within the frame (interlaced) or field (progressive) |
| oddField | output | 1 | 1 during the odd field |

## Verification
The assertions assume that `clkDirect`, `stdSel` and `interlace` change only while reset is held. Under that assumption a falling VSYNC is unambiguous: the odd-field fall comes with HSYNC low, and the even-field fall comes mid-line with HSYNC high. The assertions also assume that HSYNC_W is shorter than half a line. The stimulus follows both assumptions: every configuration, random or directed, is applied during a reset phase and held until the next one. Only `masterSel` is toggled at random while the raster runs.

// File: rtl/syncGenPkg.sv
package syncGenPkg;

  typedef enum logic [1:0] {
    STD_NTSC  = 2'd0,
    STD_PAL   = 2'd1,
    STD_PAL60 = 2'd2,
    STD_SPARE = 2'd3
  } videoStdE;

  // strobes passed from the control to the datapath
  typedef struct packed {
    logic run;   // raster running since reset release
    logic tick;  // advance the pixel counter this clock
  } syncStrobeS;

endpackage

// File: rtl/syncCtrl.sv
module syncCtrl
  import syncGenPkg::*;
#(
  parameter int LINE_525    = 858,
  parameter int LINE_625    = 864,
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int VSYNC_LINES = 3,
  localparam int MAX_PIX    = (LINE_625 > LINE_525) ? LINE_625 : LINE_525,
  localparam int MAX_LINES  = (LINES_625 > LINES_525) ? LINES_625 : LINES_525,
  localparam int PW         = $clog2(MAX_PIX + 1),
  localparam int LW         = $clog2(MAX_LINES + VSYNC_LINES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clkDirect,
  input  logic [1:0]    stdSel,
  input  logic          interlace,
  output syncStrobeS    strobe,
  output logic [PW-1:0] lineLen,
  output logic [PW-1:0] halfPix,
  output logic [LW-1:0] frameLines,
  output logic [LW-1:0] evenLine,
  output logic          ilace
);

  logic running;
  logic phase;
  logic is625;
  logic [LW-1:0] rasterLines;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
    end else begin
      running <= 1'b1;
      if (running) phase <= ~phase;
    end
  end

  always_comb begin
    is625       = (videoStdE'(stdSel) == STD_PAL);
    lineLen     = is625 ? PW'(LINE_625) : PW'(LINE_525);
    halfPix     = lineLen >> 1;
    rasterLines = is625 ? LW'(LINES_625) : LW'(LINES_525);
    frameLines  = interlace ? rasterLines : ((rasterLines + 1'b1) >> 1);
    evenLine    = (rasterLines - 1'b1) >> 1;
    ilace       = interlace;
    strobe.run  = running;
    strobe.tick = running & (clkDirect | phase);
  end

endmodule

// File: rtl/syncDatapath.sv
module syncDatapath
  import syncGenPkg::*;
#(
  parameter int PW          = 10,
  parameter int LW          = 10,
  parameter int HSYNC_W     = 64,
  parameter int VSYNC_LINES = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  syncStrobeS    strobe,
  input  logic [PW-1:0] lineLen,
  input  logic [PW-1:0] halfPix,
  input  logic [LW-1:0] frameLines,
  input  logic [LW-1:0] evenLine,
  input  logic          ilace,
  output logic          hsyncO,
  output logic          vsyncO,
  output logic [LW-1:0] lineCount,
  output logic          oddField
);

  localparam logic [PW-1:0] HSW = PW'(HSYNC_W);
  localparam logic [LW-1:0] VSL = LW'(VSYNC_LINES);

  logic [PW-1:0] pixCnt;
  logic [LW-1:0] lineCnt;
  logic [LW-1:0] evenEnd;
  logic lineEnd, frameEnd;
  logic hsActive, oddVs, evenVs, secondHalf;

  assign lineEnd  = (pixCnt >= lineLen - 1'b1);
  assign frameEnd = (lineCnt >= frameLines - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (strobe.tick) begin
      if (lineEnd) begin
        pixCnt  <= '0;
        lineCnt <= frameEnd ? '0 : lineCnt + 1'b1;
      end else begin
        pixCnt <= pixCnt + 1'b1;
      end
    end
  end

  always_comb begin
    evenEnd    = evenLine + VSL;
    hsActive   = (pixCnt < HSW);
    oddVs      = (lineCnt < VSL);
    evenVs     = ilace &&
                 (((lineCnt == evenLine) && (pixCnt >= halfPix)) ||
                  ((lineCnt > evenLine) && (lineCnt < evenEnd)) ||
                  ((lineCnt == evenEnd) && (pixCnt < halfPix)));
    secondHalf = ilace &&
                 ((lineCnt > evenLine) ||
                  ((lineCnt == evenLine) && (pixCnt >= halfPix)));
    hsyncO     = ~(strobe.run & hsActive);
    vsyncO     = ~(strobe.run & (oddVs | evenVs));
    oddField   = ~secondHalf;
    lineCount  = lineCnt;
  end

endmodule

// File: rtl/syncTimingGen.sv
module syncTimingGen
  import syncGenPkg::*;
#(
  parameter int LINE_525    = 858,
  parameter int LINE_625    = 864,
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int HSYNC_W     = 64,
  parameter int VSYNC_LINES = 3,
  localparam int MAX_PIX    = (LINE_625 > LINE_525) ? LINE_625 : LINE_525,
  localparam int MAX_LINES  = (LINES_625 > LINES_525) ? LINES_625 : LINES_525,
  localparam int PW         = $clog2(MAX_PIX + 1),
  localparam int LW         = $clog2(MAX_LINES + VSYNC_LINES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          masterSel,
  input  logic          clkDirect,
  input  logic [1:0]    stdSel,
  input  logic          interlace,
  output logic          hsyncO,
  output logic          vsyncO,
  output logic          syncOe,
  output logic [LW-1:0] lineCount,
  output logic          oddField
);

  syncStrobeS    strobe;
  logic [PW-1:0] lineLen, halfPix;
  logic [LW-1:0] frameLines, evenLine;
  logic          ilace;

  syncCtrl #(
    .LINE_525(LINE_525), .LINE_625(LINE_625),
    .LINES_525(LINES_525), .LINES_625(LINES_625),
    .VSYNC_LINES(VSYNC_LINES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .clkDirect(clkDirect), .stdSel(stdSel),
    .interlace(interlace), .strobe(strobe), .lineLen(lineLen),
    .halfPix(halfPix), .frameLines(frameLines), .evenLine(evenLine),
    .ilace(ilace)
  );

  syncDatapath #(
    .PW(PW), .LW(LW), .HSYNC_W(HSYNC_W), .VSYNC_LINES(VSYNC_LINES)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineLen(lineLen),
    .halfPix(halfPix), .frameLines(frameLines), .evenLine(evenLine),
    .ilace(ilace), .hsyncO(hsyncO), .vsyncO(vsyncO),
    .lineCount(lineCount), .oddField(oddField)
  );

  assign syncOe = masterSel;

endmodule

// File: rtl/syncTimingGenChk.sv
module syncTimingGenChk #(
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          clkDirect,
  input logic          hsyncO,
  input logic          vsyncO,
  input logic          oddField,
  input logic [LW-1:0] lineCount
);

  // R5
  odd_vs_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(vsyncO) && oddField) |-> !hsyncO);

  // R6
  even_vs_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(vsyncO) && !oddField) |-> hsyncO);

  // R8
  half_rate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkDirect && $fell(hsyncO)) |=> !hsyncO);

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineCount != $past(lineCount)) |->
      ((lineCount == '0) || (lineCount == $past(lineCount) + 1'b1)));

  // R7
  field_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oddField) |-> (lineCount == '0));

endmodule

bind syncTimingGen syncTimingGenChk #(.LW(LW)) uChk (
  .clk(clk), .rstN(rstN), .clkDirect(clkDirect), .hsyncO(hsyncO),
  .vsyncO(vsyncO), .oddField(oddField), .lineCount(lineCount)
);

// File: tb/sim_syncTimingGen.sv
module sim_syncTimingGen;

  localparam int L525 = 20, L625 = 24, N525 = 7, N625 = 9;
  localparam int HSW = 4, VSL = 2;
  localparam int LW = $clog2(N625 + VSL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterSel = 1'b1, clkDirect = 1'b1, interlace = 1'b1;
  logic [1:0] stdSel = 2'd0;
  logic hsyncO, vsyncO, syncOe, oddField;
  logic [LW-1:0] lineCount;

  int nChecks = 0, nFails = 0, clkCount = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  int mPix, mLine;
  bit mRun, mPhase;

  always #2 clk = ~clk;
  always @(posedge clk) clkCount++;

  syncTimingGen #(
    .LINE_525(L525), .LINE_625(L625), .LINES_525(N525), .LINES_625(N625),
    .HSYNC_W(HSW), .VSYNC_LINES(VSL)
  ) u0 (
    .clk(clk), .rstN(rstN), .masterSel(masterSel), .clkDirect(clkDirect),
    .stdSel(stdSel), .interlace(interlace), .hsyncO(hsyncO), .vsyncO(vsyncO),
    .syncOe(syncOe), .lineCount(lineCount), .oddField(oddField)
  );

  function automatic int rasterLines();
    return (stdSel == 2'd1) ? N625 : N525;
  endfunction
  function automatic int lineLength();
    return (stdSel == 2'd1) ? L625 : L525;
  endfunction
  function automatic int wrapLines();
    return interlace ? rasterLines() : (rasterLines() + 1) / 2;
  endfunction
  function automatic bit inEvenHalf();
    int e = (rasterLines() - 1) / 2, h = lineLength() / 2;
    return interlace && (mLine > e || (mLine == e && mPix >= h));
  endfunction
  function automatic bit expVs();
    int e = (rasterLines() - 1) / 2, h = lineLength() / 2;
    bit ev;
    ev = interlace && ((mLine == e && mPix >= h) || (mLine > e && mLine < e + VSL) ||
                       (mLine == e + VSL && mPix < h));
    return !(mRun && (mLine < VSL || ev));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic runSegment(input bit dir, input logic [1:0] std, input bit il, input int cycles);
    int lowRun = 0;
    @(negedge clk);
    rstN = 1'b0;
    clkDirect = dir; stdSel = std; interlace = il;
    repeat (3) begin
      @(negedge clk);
      check("R2 hsync in reset", hsyncO, 1);
      check("R2 vsync in reset", vsyncO, 1);
      check("R2 lineCount in reset", lineCount, 0);
      check("R2 oddField in reset", oddField, 1);
    end
    rstN = 1'b1;
    mPix = 0; mLine = 0; mRun = 0; mPhase = 0;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      if (mRun) begin
        if (dir || mPhase) begin
          if (mPix >= lineLength() - 1) begin
            mPix = 0;
            mLine = (mLine >= wrapLines() - 1) ? 0 : mLine + 1;
          end else mPix++;
        end
        mPhase = !mPhase;
      end
      mRun = 1;
      @(negedge clk);
      if (c == 0) begin
        check("R2 hsync low at restart", hsyncO, 0);
        check("R2 vsync low at restart", vsyncO, 0);
      end
      check("R3 hsync", hsyncO, !(mPix < HSW));
      check(inEvenHalf() ? "R6 even vsync" : "R5 odd vsync", vsyncO, expVs());
      check("R4 lineCount", lineCount, mLine);
      check("R7 oddField", oddField, !inEvenHalf());
      if (!hsyncO) lowRun++;
      else begin
        if (lowRun != 0) check(dir ? "R8 hsync width direct" : "R8 hsync width halved",
                               lowRun, dir ? HSW : 2 * HSW);
        lowRun = 0;
      end
      masterSel = 1'($urandom_range(0, 1));
      #0.5;
      check("R1 syncOe", syncOe, masterSel);
    end
  endtask

  initial begin
    int seedInit = $urandom(32'd1425);
    if (seedInit < 0) $display("seed");
    // directed corners: each standard, both scans, both clock modes
    runSegment(1'b1, 2'd0, 1'b1, 300);   // NTSC interlaced, full frame + wrap
    runSegment(1'b0, 2'd1, 1'b1, 500);   // PAL interlaced, halved rate
    runSegment(1'b1, 2'd2, 1'b0, 200);   // PAL60 progressive
    runSegment(1'b1, 2'd3, 1'b1, 200);   // spare code behaves as NTSC
    runSegment(1'b0, 2'd1, 1'b0, 300);   // PAL progressive, halved rate
    for (int s = 0; s < 8; s++)
      runSegment(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 150 + $urandom_range(0, 400));
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    wait (clkCount >= 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", clkCount);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule